// File: doc/BRIEF.md
# Wide-to-Narrow DMA Write Splitter

This block sits between a DMA endpoint that delivers 128-bit beats and a memory port that takes 32-bit writes. Each beat accepted over a valid/ready handshake is broken into four 32-bit writes. The lowest word goes first. Each write carries an address, data and a byte strobe.

The addresses run upward one word at a time from a parameterised base. The running address carries on from one beat to the next and only returns to the base on reset. While a beat is being flushed, the input ready is held low, so the DMA source is stalled without any extra buffering. The narrow port is assumed to take one write per cycle with no wait states.

Top module: `dma_word_splitter`

## Requirements
- R1: Every accepted beat produces exactly four writes, in four consecutive cycles with `wr_en_o` high, and no more.
- R2: The first write after reset goes to address `BASE_ADDR` (default 32'h0000_1000).
- R3: The writes of a beat carry its words in little-endian order: write k (k = 0..3) carries bits [32k+31:32k] of the beat.
- R4: Each write's address is 4 greater than that of the write before it, and this holds across beat boundaries.
- R5: `in_ready_o` is low in every cycle that shows a write. It is high again in the cycle right after the fourth write.
- R6: The first write of a beat appears in the cycle right after the clock edge at which the beat was accepted (`in_valid_i` and `in_ready_o` both high).
- R7: While `rst_ni` is low, and after it is released, `in_ready_o` is high, `wr_en_o` is low and the address restarts at `BASE_ADDR`. This holds even if reset lands in the middle of a flush.
- R8: With `in_valid_i` low, no write is issued. A beat offered while ready is low is not taken until ready returns high.
- R9: `wr_strb_o` is 4'b1111 during every write and 4'b0000 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Wide beat offered |
| in_ready_o | output | 1 | Block can take a wide beat |
| in_data_i | input | 128 | Wide beat payload |
| wr_en_o | output | 1 | Narrow write issued this cycle |
| wr_addr_o | output | 32 | Byte address of the narrow write |
| wr_data_o | output | 32 | Narrow write data |
| wr_strb_o | output | 4 | Byte strobe of the narrow write |

## Verification
A beat is accepted at a clock edge. Its four writes show on the outputs in the four cycles that follow that edge, one per cycle. Ready comes back high in the fifth cycle, so a new beat is accepted at the fifth edge after the previous one.

The bench drives inputs and samples outputs on the falling edge. After each acceptance edge it walks exactly these cycles, checking the data lane, the address, the strobe and ready in every one. When valid is held high across a flush, the bench checks that the next beat's first write appears one cycle after ready comes back. For a reset that lands mid-flush, it checks the idle outputs during reset and that the next beat restarts at the base address.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FLUSH = 1'b1
  } split_state_e;
endpackage

// File: rtl/split_ctrl.sv
module split_ctrl import splitter_pkg::*; #(
  parameter int LANES  = 4,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic load_o,
  output logic busy_o
);
  split_state_e      state_q;
  logic [LANE_W-1:0] lane_q;
  logic              last_lane;

  assign in_ready_o = (state_q == ST_IDLE);
  assign busy_o     = (state_q == ST_FLUSH);
  assign load_o     = in_valid_i && in_ready_o;
  assign last_lane  = (lane_q == LANE_W'(LANES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_o) begin
            state_q <= ST_FLUSH;
            lane_q  <= '0;
          end
        end
        ST_FLUSH: begin
          if (last_lane) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
          end else begin
            lane_q <= lane_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> busy_o && lane_q == '0); // R6
  AST_FLUSH_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !last_lane |=> busy_o); // R1
  AST_LAST_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && last_lane |=> !busy_o && in_ready_o); // R5
endmodule

// File: rtl/split_lane_buf.sv
module split_lane_buf #(
  parameter int IN_W  = 128,
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             advance_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [OUT_W-1:0] lane_o
);
  logic [IN_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= '0;
    else if (load_i) beat_q <= data_i;
    else if (advance_i) beat_q <= beat_q >> OUT_W;
  end

  // lowest word always presented; shifting exposes the next one
  assign lane_o = beat_q[OUT_W-1:0];

  AST_LOW_WORD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> lane_o == $past(data_i[OUT_W-1:0])); // R3
  AST_NEXT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i && !load_i |=> lane_o == $past(beat_q[2*OUT_W-1:OUT_W])); // R3
endmodule

// File: rtl/split_addr_gen.sv
module split_addr_gen #(
  parameter int          ADDR_W    = 32,
  parameter int          STEP      = 4,
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= ADDR_W'(BASE_ADDR);
    else if (advance_i) addr_q <= addr_q + ADDR_W'(STEP);
  end

  assign addr_o = addr_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |=> addr_o == $past(addr_o) + ADDR_W'(STEP)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> $stable(addr_o)); // R4
endmodule

// File: rtl/dma_word_splitter.sv
module dma_word_splitter #(
  parameter int          IN_W      = 128,
  parameter int          OUT_W     = 32,
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
  localparam int         LANES     = IN_W / OUT_W,
  localparam int         STRB_W    = OUT_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [IN_W-1:0]   in_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [OUT_W-1:0]  wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o
);
  logic load, busy;

  split_ctrl #(.LANES(LANES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .load_o     (load),
    .busy_o     (busy)
  );

  split_lane_buf #(.IN_W(IN_W), .OUT_W(OUT_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .advance_i (busy),
    .data_i    (in_data_i),
    .lane_o    (wr_data_o)
  );

  split_addr_gen #(.ADDR_W(ADDR_W), .STEP(STRB_W), .BASE_ADDR(BASE_ADDR)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (busy),
    .addr_o    (wr_addr_o)
  );

  assign wr_en_o   = busy;
  assign wr_strb_o = {STRB_W{busy}};

  AST_READY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !in_ready_o); // R5
  AST_NO_WRITE_WITHOUT_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(in_valid_i) && $past(in_ready_o)); // R8
endmodule

// File: tb/dma_word_splitter_tb_top.sv
module dma_word_splitter_tb_top;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int NVEC = 4;
  // beat payload, idle cycles inserted before offering it
  localparam logic [127:0] VEC_DATA [NVEC] = '{
    128'h33333333_22222222_11111111_00000000,
    128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF,
    128'hFFFFFFFF_00000000_FFFFFFFF_00000000,
    128'h80000001_7FFFFFFE_A5A5A5A5_5A5A5A5A
  };
  localparam int VEC_GAP [NVEC] = '{0, 3, 1, 0};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         in_ready, wr_en;
  logic [31:0]  wr_addr, wr_data;
  logic [3:0]   wr_strb;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_addr;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_word_splitter #(.BASE_ADDR(BASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strb_o(wr_strb)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge in which ready is high and in_valid/in_data already set.
  // Walks the acceptance edge and the four write cycles, ends on the negedge after ready returns.
  task automatic flush_and_check(input logic [127:0] beat, input bit drop_valid);
    @(posedge clk);
    @(negedge clk);
    if (drop_valid) in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(wr_en == 1'b1, "R1 wr_en", 64'(wr_en), 64'd1);
      chk(wr_data == beat[32*k +: 32], "R3 lane data", 64'(wr_data), 64'(beat[32*k +: 32]));
      chk(wr_addr == exp_addr, "R4 address", 64'(wr_addr), 64'(exp_addr));
      chk(wr_strb == 4'hF, "R9 strobe", 64'(wr_strb), 64'hF);
      chk(in_ready == 1'b0, "R5 ready low", 64'(in_ready), 64'd0);
      exp_addr = exp_addr + 32'd4;
      @(negedge clk);
    end
    chk(wr_en == 1'b0, "R1 no fifth write", 64'(wr_en), 64'd0);
    chk(in_ready == 1'b1, "R5 ready back", 64'(in_ready), 64'd1);
  endtask

  initial begin
    exp_addr = BASE;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready in reset", 64'(in_ready), 64'd1);
    chk(wr_en == 1'b0, "R7 no write in reset", 64'(wr_en), 64'd0);
    chk(wr_strb == 4'h0, "R9 strobe idle", 64'(wr_strb), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_addr == BASE, "R2 base address", 64'(wr_addr), 64'(BASE));

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int g = 0; g < VEC_GAP[v]; g++) begin
        chk(wr_en == 1'b0, "R8 quiet without valid", 64'(wr_en), 64'd0);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = VEC_DATA[v];
      flush_and_check(VEC_DATA[v], 1'b1);
    end

    // valid dropped for a while: no writes, address unchanged
    for (int i = 0; i < 5; i++) begin
      chk(wr_en == 1'b0, "R8 idle no write", 64'(wr_en), 64'd0);
      chk(wr_strb == 4'h0, "R9 idle strobe", 64'(wr_strb), 64'h0);
      @(negedge clk);
    end

    // valid held high across a flush: second beat waits for ready, then starts one cycle later (R6)
    in_valid = 1'b1;
    in_data  = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    flush_and_check(in_data, 1'b0);
    in_data  = 128'h44444444_55555555_66666666_77777777;
    flush_and_check(in_data, 1'b1);
    chk(wr_en == 1'b0, "R8 single accept per offer", 64'(wr_en), 64'd0);

    // reset in the middle of a flush
    in_valid = 1'b1;
    in_data  = 128'h1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(wr_en == 1'b1, "R1 mid flush", 64'(wr_en), 64'd1);
    rst_n = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R7 ready after async reset", 64'(in_ready), 64'd1);
    chk(wr_en == 1'b0, "R7 write cut by reset", 64'(wr_en), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_en == 1'b0, "R7 stays idle", 64'(wr_en), 64'd0);
    exp_addr = BASE;
    in_valid = 1'b1;
    in_data  = 128'hAAAA0003_AAAA0002_AAAA0001_AAAA0000;
    flush_and_check(in_data, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule